// File: doc/BRIEF.md
# Clock Interrupt Flag Unit

This block produces the three interrupt sources of a real-time clock and merges them into one request line. A programmable divider counts pulses of a 32.768 kHz base tick and raises a periodic event at the rate chosen by a 4-bit rate code. At every completed time update the current seconds, minutes, hours, date and month are compared with five alarm bytes. An alarm byte can be set to match any value. The update completion itself is also an event.

Each event sets a sticky flag in the status byte. The status byte has a summary bit that is set while any flag is set together with its enable bit. The interrupt request line follows that summary bit. Software reads the status byte by pulsing a read strobe. In the cycle of the strobe the byte shows the flags, and the strobe clears them at the next clock edge.

Top module: `rtc_irq_flags`

## Requirements
- R1: After reset the status byte is 00h and the interrupt request line is low.
- R2: Bits 3..0 of the status byte always read 0.
- R3: For a rate code n from 3 to 15, the periodic flag (status bit 6) is set on the 2^(n-1)-th base tick counted from a zero count. Codes 1 and 2 give 2^7 and 2^8 ticks. The divider is at zero after reset and after each periodic event.
- R4: A rate code of 0 stops the divider, so the periodic flag is never set.
- R5: At an update-done pulse the alarm flag (status bit 5) is set when every one of the five alarm bytes matches its time byte. The field order is seconds, minutes, hours, date, month, at index 0 to 4 of the packed buses.
- R6: An alarm byte whose bits 7..6 are both 1 (C0h to FFh) matches any time value.
- R7: Each update-done pulse sets the update flag (status bit 4).
- R8: Flags are set whatever their enables are. Status bit 7 is 1 exactly when (bit 6 and periodic enable) or (bit 5 and alarm enable) or (bit 4 and update enable) holds. The request line equals bit 7.
- R9: A read strobe clears all flags at the next edge. Without a strobe, a set flag stays set. If an event arrives in the same cycle as the strobe, its flag is set after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baseTick | input | 1 | One-cycle pulse per 32.768 kHz base period |
| rateSel | input | 4 | Periodic rate code |
| perIntEn | input | 1 | Periodic interrupt enable |
| almIntEn | input | 1 | Alarm interrupt enable |
| updIntEn | input | 1 | Update-done interrupt enable |
| updateDone | input | 1 | Pulse when a time update has finished |
| timeNow | input | 5x8 | Current time bytes (sec, min, hour, date, month) |
| alarmSet | input | 5x8 | Alarm bytes, same order |
| regCRead | input | 1 | Status byte read strobe |
| regC | output | 8 | Status byte {summary, periodic, alarm, update, 0000} |
| irq | output | 1 | Interrupt request, follows the summary bit |

## Verification
The alarm comparator is tried with time and alarm sets that agree in every byte, that differ in only the seconds byte, and that differ in only the month byte with wildcards elsewhere. This shows that all five fields take part and that a wildcard masks only its own field. The divider is run one tick short of the period and then exactly to it, for codes 3, 4, 1 and 2, which separates off-by-one periods and the remapping of the low codes. Code 0 is run for hundreds of ticks. Enables are toggled against fixed flags, and a read is made in the same cycle as an update pulse, so the clear-versus-set priority and the gating of the summary bit are each seen on their own.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int FIELD_W   = 8;
  localparam int NUM_ALARM = 5;
  localparam int RATE_W    = 4;

  typedef struct packed {
    logic periodicHit;
    logic alarmHit;
    logic updateHit;
  } irq_evt_t;
endpackage

// File: rtl/rtc_irq_datapath.sv
module rtc_irq_datapath
  import rtc_irq_pkg::*;
#(
  parameter int FW = FIELD_W,
  parameter int NA = NUM_ALARM,
  parameter int RW = RATE_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 baseTick,
  input  logic [RW-1:0]        rateSel,
  input  logic                 updateDone,
  input  logic [NA-1:0][FW-1:0] timeNow,
  input  logic [NA-1:0][FW-1:0] alarmSet,
  output irq_evt_t             evt
);
  localparam int CNT_W  = (1 << RW) - 2;
  localparam int SHIFT_W = $clog2(CNT_W + 1);

  logic [CNT_W-1:0]   divCount;
  logic [CNT_W-1:0]   divLimit;
  logic [SHIFT_W-1:0] divShift;
  logic               divHit;
  logic [NA-1:0]      fieldMatch;

  // Low codes 1 and 2 are folded onto the slower rates.
  always_comb begin
    if (rateSel == RW'(1))      divShift = SHIFT_W'(7);
    else if (rateSel == RW'(2)) divShift = SHIFT_W'(8);
    else                        divShift = SHIFT_W'(rateSel - RW'(1));
    divLimit = (CNT_W'(1) << divShift) - CNT_W'(1);
  end

  assign divHit = baseTick && (rateSel != '0) && (divCount >= divLimit);

  always_ff @(posedge clk) begin
    if (!rst_n || rateSel == '0) begin
      divCount <= '0;
    end else if (baseTick) begin
      if (divHit) divCount <= '0;
      else        divCount <= divCount + CNT_W'(1);
    end
  end

  generate
    for (genvar i = 0; i < NA; i++) begin : g_cmp
      logic anyVal;
      assign anyVal        = &alarmSet[i][FW-1:FW-2];
      assign fieldMatch[i] = anyVal || (alarmSet[i] == timeNow[i]);
    end
  endgenerate

  assign evt.periodicHit = divHit;
  assign evt.alarmHit    = updateDone && (&fieldMatch);
  assign evt.updateHit   = updateDone;
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
  import rtc_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  irq_evt_t evt,
  input  logic     regCRead,
  input  logic     perIntEn,
  input  logic     almIntEn,
  input  logic     updIntEn,
  output logic [7:0] regC,
  output logic     irq
);
  logic perFlag, almFlag, updFlag, summary;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      perFlag <= 1'b0;
      almFlag <= 1'b0;
      updFlag <= 1'b0;
    end else begin
      if (regCRead) begin
        perFlag <= 1'b0;
        almFlag <= 1'b0;
        updFlag <= 1'b0;
      end
      // A new event outranks the clear of the same edge.
      if (evt.periodicHit) perFlag <= 1'b1;
      if (evt.alarmHit)    almFlag <= 1'b1;
      if (evt.updateHit)   updFlag <= 1'b1;
    end
  end

  assign summary = (perFlag && perIntEn) || (almFlag && almIntEn) ||
                   (updFlag && updIntEn);
  assign regC    = {summary, perFlag, almFlag, updFlag, 4'b0000};
  assign irq     = summary;
endmodule

// File: rtl/rtc_irq_flags.sv
module rtc_irq_flags
  import rtc_irq_pkg::*;
#(
  parameter int FW = FIELD_W,
  parameter int NA = NUM_ALARM,
  parameter int RW = RATE_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  baseTick,
  input  logic [RW-1:0]         rateSel,
  input  logic                  perIntEn,
  input  logic                  almIntEn,
  input  logic                  updIntEn,
  input  logic                  updateDone,
  input  logic [NA-1:0][FW-1:0] timeNow,
  input  logic [NA-1:0][FW-1:0] alarmSet,
  input  logic                  regCRead,
  output logic [7:0]            regC,
  output logic                  irq
);
  irq_evt_t evt;

  rtc_irq_datapath #(.FW(FW), .NA(NA), .RW(RW)) u_dp (
    .clk(clk), .rst_n(rst_n), .baseTick(baseTick), .rateSel(rateSel),
    .updateDone(updateDone), .timeNow(timeNow), .alarmSet(alarmSet),
    .evt(evt)
  );

  rtc_irq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .evt(evt), .regCRead(regCRead),
    .perIntEn(perIntEn), .almIntEn(almIntEn), .updIntEn(updIntEn),
    .regC(regC), .irq(irq)
  );
endmodule

// File: rtl/rtc_irq_chk.sv
module rtc_irq_chk
  import rtc_irq_pkg::*;
#(
  parameter int RW = RATE_W
) (
  input logic          clk,
  input logic          rst_n,
  input logic          updateDone,
  input logic          regCRead,
  input logic [RW-1:0] rateSel,
  input logic [7:0]    regC,
  input logic          irq,
  input irq_evt_t      evt
);
  // R2
  low_nibble_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    regC[3:0] == 4'b0000);
  // R8
  irq_summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == regC[7]);
  // R7
  update_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    updateDone |=> regC[4]);
  // R5
  alarm_at_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt.alarmHit |-> updateDone);
  // R4
  rate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rateSel == '0) |-> !evt.periodicHit);
  // R3
  periodic_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt.periodicHit |=> regC[6]);
  // R9
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (regCRead && !updateDone && !evt.periodicHit) |=> (regC == 8'h00));
  // R9
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!regCRead && regC[6]) |=> regC[6]);
endmodule

bind rtc_irq_flags rtc_irq_chk #(.RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .updateDone(updateDone), .regCRead(regCRead),
  .rateSel(rateSel), .regC(regC), .irq(irq), .evt(evt)
);

// File: tb/rtc_irq_flags_tb.sv
module rtc_irq_flags_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic baseTick = 1'b0;
  logic [3:0] rateSel = 4'd0;
  logic perIntEn = 1'b0, almIntEn = 1'b0, updIntEn = 1'b0;
  logic updateDone = 1'b0;
  logic [4:0][7:0] timeNow = '0;
  logic [4:0][7:0] alarmSet = '0;
  logic regCRead = 1'b0;
  logic [7:0] regC;
  logic irq;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  logic [7:0] expQ[$];
  string tagQ[$];

  always #2.5 clk = ~clk;

  rtc_irq_flags u_dut (
    .clk(clk), .rst_n(rst_n), .baseTick(baseTick), .rateSel(rateSel),
    .perIntEn(perIntEn), .almIntEn(almIntEn), .updIntEn(updIntEn),
    .updateDone(updateDone), .timeNow(timeNow), .alarmSet(alarmSet),
    .regCRead(regCRead), .regC(regC), .irq(irq)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // Monitor: pops an expected status byte for every read strobe seen.
  always @(negedge clk) begin
    if (regCRead && expQ.size() > 0) begin
      automatic logic [7:0] e = expQ.pop_front();
      automatic string t = tagQ.pop_front();
      check(regC == e, t, regC, e);
      check(regC[3:0] == 4'b0, "R2 low nibble", regC, {regC[7:4], 4'b0});
      check(irq == regC[7], "R8 irq follows bit7", irq, regC[7]);
    end
  end

  task automatic readC(input logic [7:0] e, input string t, input bit withUpd = 1'b0);
    expQ.push_back(e);
    tagQ.push_back(t);
    regCRead = 1'b1;
    updateDone = withUpd;
    @(posedge clk); #1;
    regCRead = 1'b0;
    updateDone = 1'b0;
  endtask

  task automatic pulseUpdate();
    updateDone = 1'b1;
    @(posedge clk); #1;
    updateDone = 1'b0;
  endtask

  task automatic ticks(input int n);
    baseTick = 1'b1;
    repeat (n) @(posedge clk);
    #1 baseTick = 1'b0;
  endtask

  task automatic checkIrq(input logic e, input string t);
    @(negedge clk);
    check(irq == e, t, irq, e);
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(regC == 8'h00, "R1 reset regC", regC, 8'h00);
    check(irq == 1'b0, "R1 reset irq", irq, 0);
    @(posedge clk); #1;

    // R7 update flag, seconds differ so no alarm, enables off
    timeNow  = {8'h07, 8'h15, 8'h12, 8'h34, 8'h05};
    alarmSet = {8'h07, 8'h15, 8'h12, 8'h34, 8'h06};
    pulseUpdate();
    checkIrq(1'b0, "R8 flag without enable");
    readC(8'h10, "R7 update flag");
    readC(8'h00, "R9 cleared after read");

    // R8 enabled update flag raises summary
    updIntEn = 1'b1;
    pulseUpdate();
    checkIrq(1'b1, "R8 irq with update enable");
    readC(8'h90, "R8 summary from update");
    checkIrq(1'b0, "R9 irq drops after read");

    // R5 full alarm match
    updIntEn = 1'b0; almIntEn = 1'b1;
    alarmSet = timeNow;
    pulseUpdate();
    readC(8'hB0, "R5 alarm match");

    // R6 wildcards on seconds and hours
    almIntEn = 1'b0;
    timeNow[0]  = 8'h17;
    alarmSet[0] = 8'hC0;
    alarmSet[2] = 8'hFF;
    pulseUpdate();
    readC(8'h30, "R6 wildcard match");
    // R6 month differs, wildcards elsewhere do not mask it
    alarmSet[4] = 8'h08;
    pulseUpdate();
    readC(8'h10, "R6 month mismatch");

    // R3 rate code 3: 4 ticks
    rateSel = 4'd3;
    @(posedge clk); #1;
    ticks(3);
    readC(8'h00, "R3 code3 before period");
    ticks(1);
    readC(8'h40, "R3 code3 period");
    readC(8'h00, "R9 periodic cleared");
    // R3 code 4: 8 ticks with enable
    perIntEn = 1'b1;
    rateSel = 4'd4;
    ticks(7);
    readC(8'h00, "R3 code4 before period");
    ticks(1);
    checkIrq(1'b1, "R8 irq from periodic");
    readC(8'hC0, "R3 code4 period");
    // R3 code 1: 128 ticks
    rateSel = 4'd1;
    ticks(127);
    readC(8'h00, "R3 code1 before period");
    ticks(1);
    readC(8'hC0, "R3 code1 period");
    // R3 code 2: 256 ticks
    rateSel = 4'd2;
    ticks(255);
    readC(8'h00, "R3 code2 before period");
    ticks(1);
    readC(8'hC0, "R3 code2 period");

    // R8 flag stays, enable gates summary only
    perIntEn = 1'b0;
    @(posedge clk); #1;
    readC(8'h00, "R8 nothing pending");

    // R4 code 0 stops divider
    rateSel = 4'd0;
    ticks(300);
    readC(8'h00, "R4 code0 no periodic");

    // R9 event in same cycle as read wins
    readC(8'h00, "R9 read with update", 1'b1);
    readC(8'h10, "R9 event kept over clear");

    repeat (3) @(posedge clk);
    check(expQ.size() == 0, "scoreboard drained", expQ.size(), 0);
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule